// File: doc/BRIEF.md
# DRAM Calibration-Register Read Mode Controller

This block sits on the device side of a DDR3-style memory model. Every rising clock edge it samples the active-low command strobes, the bank-address bits and the address bus. It recognises mode-register-set commands and keeps the state of the calibration-register mode. It holds a two-state machine with the states `ST_NORMAL` and `ST_MPR`. The transition `ENTER` goes from `ST_NORMAL` to `ST_MPR`. It fires on a mode-register-3 write that has A2 set and all reserved bits clear, while every bank reports idle. The transition `EXIT` goes from `ST_MPR` to `ST_NORMAL`. It fires on a mode-register-3 write that has A2 clear and all reserved bits clear. An active-low reset forces `ST_NORMAL` from either state.

While the machine is in `ST_MPR`, a read command does not reach the memory array. The block answers it with a fixed burst chosen by the location field A1:A0 that was latched on entry. Any command that is not allowed in this mode raises a one-cycle illegal-command pulse. In `ST_NORMAL` the block stays quiet, except that it flags malformed or badly timed mode-register writes. The surrounding model uses the redirect flag to choose between array data and the burst on `rd_pattern`.

Top module: `mpr_mode_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `rd_redirect`, `cmd_illegal` and `rd_pattern` are all 0 and the machine is in `ST_NORMAL`.
- R2: A mode-register-set command is cs_n=ras_n=cas_n=we_n=0. BA=011 addresses mode register 3. A mode-register-set with BA2=1 raises `cmd_illegal` one cycle later. In `ST_NORMAL`, writes to the other registers (BA=000, 001, 010) raise nothing.
- R3: In `ST_NORMAL`, a mode-register-3 write with A2=1, A[14:3]=0 and `banks_idle`=1 moves the machine to `ST_MPR` and latches A1:A0 as the location. It raises no flag.
- R4: A mode-register-3 write with A2=1 while `banks_idle`=0 raises `cmd_illegal` and leaves the machine in `ST_NORMAL`.
- R5: A mode-register-3 write with any bit of A[14:3] set raises `cmd_illegal` and does not change the state or the location.
- R6: In `ST_MPR`, a read command (cs_n=0, ras_n=1, cas_n=0, we_n=1) sets `rd_redirect`=1 for the next cycle. The result is the same whether A10 is 0 or 1 (autoprecharge variant).
- R7: The burst is packed beat by beat: beat b occupies `rd_pattern[16*b+15:16*b]`. For location 0, every lane of beat b carries the value b mod 2, so the word is FFFF0000 repeated four times. Locations 1 to 3 return all zeros.
- R8: In `ST_MPR`, every command other than a read, a NOP (cs_n=0, others 1), a deselect (cs_n=1) or an `EXIT` write raises `cmd_illegal` and leaves the mode on. This includes refresh, activate, write, other mode registers and a mode-register-3 write with A2=1.
- R9: An `EXIT` write returns the machine to `ST_NORMAL`. A1:A0 are ignored on this write and raise no flag.
- R10: In `ST_NORMAL`, reads leave `rd_redirect`=0 and `rd_pattern`=0, and ordinary commands raise no flag.
- R11: Asserting reset during `ST_MPR` returns the machine to `ST_NORMAL`. A later read is not redirected.
- R12: The outputs are registered. They change in the cycle after the sampling edge and last exactly one cycle for each command, so back-to-back reads give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address / mode-register select |
| addr | input | ADDR_W (15) | Address bus |
| banks_idle | input | 1 | High when all banks are precharged and the precharge time has been met |
| rd_pattern | output | DQ_W*BURST (128) | Burst returned for a redirected read, zero otherwise |
| rd_redirect | output | 1 | One-cycle pulse: the read was served from the calibration register |
| cmd_illegal | output | 1 | One-cycle pulse: the command was not allowed or was malformed |

## Verification
The hardest situation to reach is a mode-register-3 write that is refused while the mode is already on. Such a write must leave both the mode and the latched location untouched, and the refusal can only be seen through what the following reads return. To reach it, the stimulus enters the mode with a non-zero location, which gives an all-zero burst. It then sends rejected writes with A2=1 or with a reserved bit set, and issues reads after each one. Those reads must keep returning redirected zeros rather than the location-0 pattern or normal reads. A separate sequence asserts reset in the middle of the mode and shows that the first read afterwards is no longer redirected.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef enum logic [0:0] {
        ST_NORMAL = 1'b0,
        ST_MPR    = 1'b1
    } mpr_state_e;

    typedef struct packed {
        logic mrs;       // mode-register-set
        logic rd;        // read or read with autoprecharge
        logic quiet;     // deselect or no-operation
    } cmd_dec_t;

    localparam logic [2:0] MR3_SEL = 3'b011;

endpackage

// File: rtl/mpr_cmd_decode.sv
module mpr_cmd_decode
    import mpr_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output cmd_dec_t dec
);

    always_comb begin
        dec.quiet = cs_n | (ras_n & cas_n & we_n);
        dec.mrs   = ~cs_n & ~ras_n & ~cas_n & ~we_n;
        dec.rd    = ~cs_n &  ras_n & ~cas_n &  we_n;
    end

endmodule

// File: rtl/mpr_pattern_gen.sv
module mpr_pattern_gen #(
    parameter int DQ_W  = 16,
    parameter int BURST = 8,
    parameter int LOC_W = 2
) (
    input  logic [LOC_W-1:0]      loc,
    output logic [DQ_W*BURST-1:0] pattern
);

    for (genvar b = 0; b < BURST; b++) begin : g_beat
        localparam logic BIT_VAL = 1'((b % 2) == 1);
        assign pattern[b*DQ_W +: DQ_W] = (loc == '0) ? {DQ_W{BIT_VAL}} : '0;
    end

endmodule

// File: rtl/mpr_mode_fsm.sv
module mpr_mode_fsm
    import mpr_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int LOC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_dec_t          dec,
    input  logic [2:0]        ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic              banks_idle,
    output mpr_state_e        state_q,
    output logic [LOC_W-1:0]  loc_q,
    output logic              rd_hit,
    output logic              redirect_q,
    output logic              illegal_q
);

    mpr_state_e       state_d;
    logic [LOC_W-1:0] loc_d;
    logic             illegal_d;
    logic             mr3_wr;
    logic             rsvd_bad;
    logic             mr3_ok;
    logic             bad_bank;

    assign mr3_wr   = dec.mrs && (ba == MR3_SEL);
    assign rsvd_bad = |addr[ADDR_W-1:3];
    assign mr3_ok   = mr3_wr && !rsvd_bad;
    assign bad_bank = dec.mrs && ba[2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            loc_q   <= '0;
        end else begin
            state_q <= state_d;
            loc_q   <= loc_d;
        end
    end

    // next state and flag decision
    always_comb begin
        state_d   = state_q;
        loc_d     = loc_q;
        illegal_d = 1'b0;
        rd_hit    = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                if (mr3_ok && addr[2] && banks_idle) begin
                    state_d = ST_MPR;                 // ENTER
                    loc_d   = addr[LOC_W-1:0];
                end
                illegal_d = bad_bank
                          || (mr3_wr && rsvd_bad)
                          || (mr3_ok && addr[2] && !banks_idle);
            end
            ST_MPR: begin
                rd_hit = dec.rd;
                if (mr3_ok && !addr[2]) begin
                    state_d = ST_NORMAL;              // EXIT
                end
                illegal_d = !(dec.quiet || dec.rd || (mr3_ok && !addr[2]));
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_q <= 1'b0;
            illegal_q  <= 1'b0;
        end else begin
            redirect_q <= rd_hit;
            illegal_q  <= illegal_d;
        end
    end

endmodule

// File: rtl/mpr_mode_ctrl.sv
module mpr_mode_ctrl
    import mpr_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DQ_W   = 16,
    parameter int BURST  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [2:0]            ba,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  banks_idle,
    output logic [DQ_W*BURST-1:0] rd_pattern,
    output logic                  rd_redirect,
    output logic                  cmd_illegal
);

    localparam int LOC_W  = 2;
    localparam int DATA_W = DQ_W * BURST;

    cmd_dec_t          dec;
    mpr_state_e        mode_state;
    logic [LOC_W-1:0]  loc_q;
    logic              rd_hit;
    logic [DATA_W-1:0] pattern;
    logic [DATA_W-1:0] data_q;

    mpr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .dec   (dec)
    );

    mpr_mode_fsm #(
        .ADDR_W (ADDR_W),
        .LOC_W  (LOC_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec        (dec),
        .ba         (ba),
        .addr       (addr),
        .banks_idle (banks_idle),
        .state_q    (mode_state),
        .loc_q      (loc_q),
        .rd_hit     (rd_hit),
        .redirect_q (rd_redirect),
        .illegal_q  (cmd_illegal)
    );

    mpr_pattern_gen #(
        .DQ_W  (DQ_W),
        .BURST (BURST),
        .LOC_W (LOC_W)
    ) u_pat (
        .loc     (loc_q),
        .pattern (pattern)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= rd_hit ? pattern : '0;
        end
    end

    assign rd_pattern = data_q;

endmodule

// File: rtl/mpr_mode_ctrl_chk.sv
module mpr_mode_ctrl_chk
    import mpr_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [2:0]        ba,
    input logic [ADDR_W-1:0] addr,
    input logic              banks_idle,
    input logic [DATA_W-1:0] rd_pattern,
    input logic              rd_redirect,
    input logic              cmd_illegal,
    input mpr_state_e        mode_state
);

    logic pin_mrs;
    logic pin_rd;
    assign pin_mrs = !cs_n && !ras_n && !cas_n && !we_n;
    assign pin_rd  = !cs_n &&  ras_n && !cas_n &&  we_n;

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (mode_state == ST_NORMAL && !rd_redirect && !cmd_illegal);
        end
    end

    assert_bad_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mrs && ba[2]) |=> cmd_illegal);

    assert_busy_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == ST_NORMAL && pin_mrs && ba == 3'b011 && addr[2] && !banks_idle)
        |=> (cmd_illegal && mode_state == ST_NORMAL));

    assert_rsvd_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mrs && ba == 3'b011 && (|addr[ADDR_W-1:3])) |=> (cmd_illegal && $stable(mode_state)));

    assert_redirect_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_redirect |-> $past(pin_rd && mode_state == ST_MPR));

    assert_quiet_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pattern != '0) |-> rd_redirect);

    assert_flag_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_redirect && cmd_illegal));

endmodule

bind mpr_mode_ctrl mpr_mode_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DQ_W * BURST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ba          (ba),
    .addr        (addr),
    .banks_idle  (banks_idle),
    .rd_pattern  (rd_pattern),
    .rd_redirect (rd_redirect),
    .cmd_illegal (cmd_illegal),
    .mode_state  (mode_state)
);

// File: tb/mpr_mode_ctrl_tb.sv
module mpr_mode_ctrl_tb;

    localparam logic [3:0] C_DES = 4'b1111;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    typedef struct packed {
        logic [3:0]  cmd;   // {cs_n, ras_n, cas_n, we_n}
        logic [2:0]  ba;
        logic [14:0] addr;
        logic        idle;
        logic        e_rd;
        logic        e_ill;
        logic        e_pat; // expect the location-0 burst
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{C_RD,  3'd0, 15'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 read in normal
        '{C_ACT, 3'd0, 15'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 activate quiet
        '{C_MRS, 3'd3, 15'h0004, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 entry while busy
        '{C_RD,  3'd0, 15'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 still normal
        '{C_MRS, 3'd3, 15'h000C, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 A3 set
        '{C_RD,  3'd0, 15'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 no entry
        '{C_MRS, 3'd4, 15'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 BA2 high
        '{C_MRS, 3'd0, 15'h0123, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 MR0 write quiet
        '{C_MRS, 3'd3, 15'h0004, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 ENTER loc 0
        '{C_RD,  3'd0, 15'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 pattern
        '{C_RD,  3'd0, 15'h0400, 1'b1, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 A10 variant
        '{C_NOP, 3'd0, 15'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd12}, // R12 pulse ends
        '{C_REF, 3'd0, 15'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 refresh
        '{C_ACT, 3'd0, 15'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 activate
        '{C_WR,  3'd0, 15'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 write
        '{C_MRS, 3'd1, 15'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 MR1 in mode
        '{C_MRS, 3'd3, 15'h0005, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 MR3 A2=1 in mode
        '{C_RD,  3'd0, 15'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 4'd8},  // R8 loc unchanged
        '{C_MRS, 3'd3, 15'h0003, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 EXIT, A1:A0 ignored
        '{C_RD,  3'd0, 15'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 normal again
        '{C_MRS, 3'd3, 15'h0006, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 ENTER loc 2
        '{C_RD,  3'd0, 15'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 reserved loc zeros
        '{C_DES, 3'd0, 15'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 deselect legal
        '{C_MRS, 3'd3, 15'h4000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 A14 set in mode
        '{C_RD,  3'd0, 15'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5}   // R5 mode kept
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]   ba = '0;
    logic [14:0]  addr = '0;
    logic         banks_idle = 1'b1;
    logic [127:0] rd_pattern;
    logic         rd_redirect;
    logic         cmd_illegal;

    int n_run = 0;
    int n_fail = 0;
    logic [127:0] pat0;

    always #4 clk = ~clk;

    mpr_mode_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .ba          (ba),
        .addr        (addr),
        .banks_idle  (banks_idle),
        .rd_pattern  (rd_pattern),
        .rd_redirect (rd_redirect),
        .cmd_illegal (cmd_illegal)
    );

    task automatic chk(input logic ok, input int req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic [2:0] b,
                         input logic [14:0] a, input logic idl);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba = b;
        addr = a;
        banks_idle = idl;
    endtask

    task automatic step_check(input logic [3:0] c, input logic [2:0] b,
                              input logic [14:0] a, input logic idl,
                              input logic e_rd, input logic e_ill,
                              input logic [127:0] e_data, input int req);
        drive(c, b, a, idl);
        @(posedge clk);
        @(negedge clk);
        chk(rd_redirect === e_rd, req, "redirect", 128'(rd_redirect), 128'(e_rd));
        chk(cmd_illegal === e_ill, req, "illegal", 128'(cmd_illegal), 128'(e_ill));
        chk(rd_pattern === e_data, req, "pattern", rd_pattern, e_data);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R7 expected burst: beat b lanes = b mod 2
        pat0 = '0;
        for (int b = 0; b < 8; b++) pat0[b*16 +: 16] = (b % 2 == 1) ? 16'hFFFF : 16'h0000;

        // R1 reset state
        repeat (2) @(negedge clk);
        chk(rd_redirect === 1'b0, 1, "redirect in reset", 128'(rd_redirect), 128'd0);
        chk(cmd_illegal === 1'b0, 1, "illegal in reset", 128'(cmd_illegal), 128'd0);
        chk(rd_pattern === '0, 1, "pattern in reset", rd_pattern, 128'd0);
        rst_n = 1'b1;
        drive(C_NOP, 3'd0, 15'h0, 1'b1);
        @(negedge clk);
        chk(rd_redirect === 1'b0 && cmd_illegal === 1'b0, 1, "flags after reset",
            {126'd0, rd_redirect, cmd_illegal}, 128'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            step_check(VEC[i].cmd, VEC[i].ba, VEC[i].addr, VEC[i].idle,
                       VEC[i].e_rd, VEC[i].e_ill,
                       (VEC[i].e_rd && VEC[i].e_pat) ? pat0 : 128'd0, int'(VEC[i].req));
        end

        // R11 reset during mode (currently in mode, location 2)
        drive(C_NOP, 3'd0, 15'h0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(rd_redirect === 1'b0 && cmd_illegal === 1'b0, 11, "flags in reset",
            {126'd0, rd_redirect, cmd_illegal}, 128'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step_check(C_RD, 3'd0, 15'h0, 1'b1, 1'b0, 1'b0, 128'd0, 11);

        // R12 back-to-back reads give back-to-back pulses, then drop
        step_check(C_MRS, 3'd3, 15'h0004, 1'b1, 1'b0, 1'b0, 128'd0, 3);
        step_check(C_RD, 3'd0, 15'h0000, 1'b1, 1'b1, 1'b0, pat0, 12);
        step_check(C_RD, 3'd0, 15'h0400, 1'b1, 1'b1, 1'b0, pat0, 12);
        step_check(C_NOP, 3'd0, 15'h0000, 1'b1, 1'b0, 1'b0, 128'd0, 12);
        // R4 banks_idle has no effect on reads inside the mode
        step_check(C_RD, 3'd0, 15'h0000, 1'b0, 1'b1, 1'b0, pat0, 4);
        // R9 exit then re-entry attempt while busy is refused
        step_check(C_MRS, 3'd3, 15'h0000, 1'b0, 1'b0, 1'b0, 128'd0, 9);
        step_check(C_MRS, 3'd3, 15'h0004, 1'b0, 1'b0, 1'b1, 128'd0, 4);
        step_check(C_RD, 3'd0, 15'h0000, 1'b1, 1'b0, 1'b0, 128'd0, 10);

        drive(C_NOP, 3'd0, 15'h0, 1'b1);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule